// File: doc/BRIEF.md
# Bus Clock Prescaler and Interface Clock Gate

This block divides a main clock into a CPU clock enable and one clock enable per peripheral bus. The CPU and the high-speed bus share one power-of-two prescaler. Each peripheral bus adds its own power-of-two prescaler on top of the CPU ratio. One free-running counter produces every strobe. A bus strobe therefore only ever lands on a cycle that also carries a CPU strobe, which keeps all buses in phase.

A mask register for each bus turns the interface clock of each peripheral on that bus on or off. The same masks guard a peripheral access path. A read from a masked peripheral returns zero, and a write to a masked peripheral is not passed on.

Prescaler settings written on the configuration port wait in shadow registers. They become active together when the shared counter wraps, so a change never produces an enable period shorter than the old or the new ratio.

Top module: `bus_clk_gate`

## Requirements
- R1: After reset the CPU ratio and every bus ratio are 1, so `cpu_en` and all `bus_en` bits are high on every cycle. The masks take the value `RST_MASK`: by default bus 0 has all eight peripherals on, bus 1 has peripherals 0 to 3 on, and bus 2 has none.
- R2: `cpu_en` pulses for one cycle every 2^N cycles. N is the active CPU setting, taken from bits [2:0] of configuration address 0.
- R3: `bus_en[b]` pulses every 2^(N+M) cycles. M is the active setting of bus b, taken from bits [2:0] of address 1+b. `bus_en[b]` is never high on a cycle where `cpu_en` is low.
- R4: `periph_en[b*8+i]` equals `bus_en[b]` ANDed with bit i of the mask of bus b.
- R5: A read access (`pa_valid` high, `pa_write` low) returns `pa_rdata_in` when the addressed peripheral is unmasked. It returns zero when that peripheral is masked, when the bus index is 3 or more, or when there is no access.
- R6: A write access asserts `pa_wr_fwd` in the same cycle only when the addressed peripheral is unmasked. Writes to masked peripherals are dropped.
- R7: New prescaler settings take effect together at the cycle after the shared counter completes its longest active period. Until then the old ratios hold, so no enable period is cut short.
- R8: `cfg_rdata` returns the programmed value of the register at `cfg_addr`. Address 0 holds the CPU ratio, addresses 1 to 3 hold the bus ratios, and addresses 4 to 6 hold the masks in bits [7:0]. Every other address reads as zero. Mask writes apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_wr | input | 1 | configuration write strobe |
| cfg_addr | input | AW (4) | configuration register address |
| cfg_wdata | input | DW (32) | configuration write data |
| cfg_rdata | output | DW (32) | configuration read data (combinational) |
| cpu_en | output | 1 | CPU and high-speed bus clock enable |
| bus_en | output | NB (3) | peripheral bus clock enables |
| periph_en | output | NB*PW (24) | per-peripheral interface clock enables |
| pa_valid | input | 1 | peripheral access valid |
| pa_write | input | 1 | peripheral access is a write |
| pa_bus | input | 2 | bus index of the access |
| pa_idx | input | 3 | peripheral index on that bus |
| pa_rdata_in | input | DW (32) | read data from the peripheral |
| pa_rdata | output | DW (32) | gated read data |
| pa_wr_fwd | output | 1 | write strobe passed to the peripheral |

## Verification
The enables depend on a counter that advances at each rising edge. Their expected values therefore come from a reference model that steps once at each rising edge and applies any write seen at that edge after it handles a wrap. The bench compares each new output half a cycle after the edge.

The access path and `cfg_rdata` are combinational. They are due in the same cycle as their inputs, so they are checked a few nanoseconds after the falling edge that drives those inputs. Mask writes show up one edge later, as does the reset state of R1.

A ratio change is due only after the next counter wrap. This can be up to 16384 cycles for the largest settings, so the bench idles long enough to cover that case.

// File: rtl/bus_clk_gate.sv
module bus_clk_gate #(
  parameter int NB = 3,
  parameter int PW = 8,
  parameter int DIV_W = 3,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [NB*PW-1:0] RST_MASK = 24'h000FFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  output logic [DW-1:0]         cfg_rdata,
  output logic                  cpu_en,
  output logic [NB-1:0]         bus_en,
  output logic [NB*PW-1:0]      periph_en,
  input  logic                  pa_valid,
  input  logic                  pa_write,
  input  logic [BSW-1:0]        pa_bus,
  input  logic [ISW-1:0]        pa_idx,
  input  logic [DW-1:0]         pa_rdata_in,
  output logic [DW-1:0]         pa_rdata,
  output logic                  pa_wr_fwd
);
  localparam int BSW = (NB > 1) ? $clog2(NB + 1) : 1;
  localparam int ISW = (PW > 1) ? $clog2(PW) : 1;
  localparam int MAXSH = (1 << DIV_W) - 1;
  localparam int CW = 2 * MAXSH;

  logic [DIV_W-1:0]          cpu_sh, cpu_act;
  logic [NB-1:0][DIV_W-1:0]  bus_sh, bus_act;
  logic [NB-1:0][PW-1:0]     mask;
  logic [CW-1:0]             cnt, top;
  logic                      wrap;
  int                        mx;

  function automatic logic [CW-1:0] ones(input int n);
    return {CW{1'b1}} >> (CW - n);
  endfunction

  always_comb begin
    mx = 0;
    for (int b = 0; b < NB; b++)
      if (int'(bus_act[b]) > mx) mx = int'(bus_act[b]);
  end

  assign top  = ones(int'(cpu_act) + mx);
  assign wrap = (cnt == top);
  assign cpu_en = ((cnt & ones(int'(cpu_act))) == ones(int'(cpu_act)));

  for (genvar b = 0; b < NB; b++) begin : g_bus
    logic [CW-1:0] bm;
    assign bm = ones(int'(cpu_act) + int'(bus_act[b]));
    assign bus_en[b] = ((cnt & bm) == bm);
    assign periph_en[b*PW +: PW] = mask[b] & {PW{bus_en[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cpu_act <= '0;
      bus_act <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      cpu_act <= cpu_sh;
      bus_act <= bus_sh;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_sh <= '0;
      bus_sh <= '0;
      mask   <= RST_MASK;
    end else if (cfg_wr) begin
      if (cfg_addr == AW'(0)) cpu_sh <= cfg_wdata[DIV_W-1:0];
      for (int b = 0; b < NB; b++) begin
        if (cfg_addr == AW'(1 + b))      bus_sh[b] <= cfg_wdata[DIV_W-1:0];
        if (cfg_addr == AW'(1 + NB + b)) mask[b]   <= cfg_wdata[PW-1:0];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(0)) cfg_rdata[DIV_W-1:0] = cpu_sh;
    for (int b = 0; b < NB; b++) begin
      if (cfg_addr == AW'(1 + b))      cfg_rdata[DIV_W-1:0] = bus_sh[b];
      if (cfg_addr == AW'(1 + NB + b)) cfg_rdata[PW-1:0]    = mask[b];
    end
  end

  logic open_path;
  always_comb begin
    open_path = 1'b0;
    for (int b = 0; b < NB; b++)
      if (pa_bus == BSW'(b)) open_path = mask[b][pa_idx];
  end

  assign pa_rdata  = (pa_valid && !pa_write && open_path) ? pa_rdata_in : '0;
  assign pa_wr_fwd = pa_valid && pa_write && open_path;
endmodule

// File: rtl/bus_clk_gate_chk.sv
module bus_clk_gate_chk #(
  parameter int NB = 3,
  parameter int PW = 8,
  parameter int DIV_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_en,
  input logic [NB-1:0]     bus_en,
  input logic [NB*PW-1:0]  periph_en,
  input logic              pa_valid,
  input logic              pa_write,
  input logic              pa_wr_fwd,
  input logic [DIV_W-1:0]  act_cpu
);
  logic [NB*PW-1:0] bus_x;
  for (genvar b = 0; b < NB; b++) begin : g_x
    assign bus_x[b*PW +: PW] = {PW{bus_en[b]}};
  end

  logic first, seen;
  logic [31:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first <= 1'b1;
      seen  <= 1'b0;
      gap   <= '0;
    end else begin
      first <= 1'b0;
      if (cpu_en) begin
        seen <= 1'b1;
        gap  <= '0;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  a_r1_reset_div1: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> (cpu_en && (&bus_en)));

  a_r2_cpu_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && seen) |-> ((gap + 1) == (32'd1 << act_cpu)));

  a_r3_bus_on_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_en) |-> cpu_en);

  a_r4_periph_in_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en & ~bus_x) == '0);

  a_r6_write_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    pa_wr_fwd |-> (pa_valid && pa_write));
endmodule

bind bus_clk_gate bus_clk_gate_chk #(.NB(NB), .PW(PW), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .bus_en(bus_en),
  .periph_en(periph_en), .pa_valid(pa_valid), .pa_write(pa_write),
  .pa_wr_fwd(pa_wr_fwd), .act_cpu(cpu_act)
);

// File: tb/tb_bus_clk_gate.sv
`timescale 1ns/1ps
module tb_bus_clk_gate;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [3:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic cpu_en;
  logic [2:0] bus_en;
  logic [23:0] periph_en;
  logic pa_valid, pa_write, pa_wr_fwd;
  logic [1:0] pa_bus;
  logic [2:0] pa_idx;
  logic [31:0] pa_rdata_in, pa_rdata;

  always #4 clk = ~clk;

  bus_clk_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_en(cpu_en),
    .bus_en(bus_en), .periph_en(periph_en), .pa_valid(pa_valid),
    .pa_write(pa_write), .pa_bus(pa_bus), .pa_idx(pa_idx),
    .pa_rdata_in(pa_rdata_in), .pa_rdata(pa_rdata), .pa_wr_fwd(pa_wr_fwd)
  );

  int total = 0, fails = 0;
  bit done = 0, first = 0;
  int m_cpu, m_cpus, t, lng, mx;
  int m_bus[3], m_buss[3], m_mask[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cpu = 0; m_cpus = 0; t = 0;
      for (int b = 0; b < 3; b++) begin
        m_bus[b] = 0; m_buss[b] = 0;
      end
      m_mask[0] = 'hFF; m_mask[1] = 'h0F; m_mask[2] = 'h00;
    end else begin
      mx = 0;
      for (int b = 0; b < 3; b++) if (m_bus[b] > mx) mx = m_bus[b];
      lng = m_cpu + mx;
      if (((t + 1) % (1 << lng)) == 0) begin
        t = 0; m_cpu = m_cpus;
        for (int b = 0; b < 3; b++) m_bus[b] = m_buss[b];
      end else t++;
      if (cfg_wr) begin
        if (cfg_addr == 0) m_cpus = cfg_wdata & 7;
        else if (cfg_addr >= 1 && cfg_addr <= 3) m_buss[cfg_addr-1] = cfg_wdata & 7;
        else if (cfg_addr >= 4 && cfg_addr <= 6) m_mask[cfg_addr-4] = cfg_wdata & 'hFF;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic ecpu, open;
      logic [2:0] ebus;
      logic [23:0] eper;
      logic [31:0] erd, ecfg;
      logic ewf;
      ecpu = ((t + 1) % (1 << m_cpu)) == 0;
      for (int b = 0; b < 3; b++) begin
        ebus[b] = ((t + 1) % (1 << (m_cpu + m_bus[b]))) == 0;
        eper[b*8 +: 8] = ebus[b] ? m_mask[b][7:0] : 8'h00;
      end
      open = (pa_bus < 3) && m_mask[pa_bus][pa_idx];
      erd = (pa_valid && !pa_write && open) ? pa_rdata_in : 32'h0;
      ewf = pa_valid && pa_write && open;
      if (cfg_addr == 0) ecfg = m_cpus;
      else if (cfg_addr <= 3) ecfg = m_buss[cfg_addr-1];
      else if (cfg_addr <= 6) ecfg = m_mask[cfg_addr-4];
      else ecfg = 0;
      if (first) begin
        chk("R1 cpu_en", cpu_en, 1);
        chk("R1 bus_en", bus_en, 3'b111);
        chk("R1 periph_en", periph_en, 24'h000FFF);
        first = 0;
      end
      chk("R2 R7 cpu_en", cpu_en, ecpu);
      chk("R3 R7 bus_en", bus_en, ebus);
      chk("R4 periph_en", periph_en, eper);
      chk("R5 pa_rdata", pa_rdata, erd);
      chk("R6 pa_wr_fwd", pa_wr_fwd, ewf);
      chk("R8 cfg_rdata", cfg_rdata, ecfg);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic traffic(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pa_valid = $urandom % 2; pa_write = $urandom % 2;
      pa_bus = $urandom % 4; pa_idx = $urandom % 8;
      pa_rdata_in = $urandom;
    end
    @(negedge clk);
    pa_valid = 0;
  endtask

  initial begin
    #(250000 * 8);
    if (!done) begin
      done = 1; fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    pa_valid = 0; pa_write = 0; pa_bus = 0; pa_idx = 0; pa_rdata_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; first = 1;
    idle(10);
    wr(0, 2); idle(100);
    wr(1, 1); wr(2, 0); wr(3, 3); idle(600);
    wr(0, 1); idle(600);
    traffic(300);
    wr(4, 'h5A); wr(5, 'hF0); wr(6, 'h81);
    traffic(600);
    wr(0, 3); wr(3, 2); traffic(800);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); cfg_addr = a[3:0];
    end
    wr(0, 7); wr(3, 7); idle(40000);
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0); idle(20000);
    wr(4, 0); traffic(200);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule